// File: doc/BRIEF.md
# Auto-Advancing Indirect Register Port

This block gives a host processor access to a bank of 16-bit registers through one data port. The host first loads an index. After that, each completed access moves to the next register, so the host can stream through the bank without loading a new index each time. Two byte-lane enables let a host with an 8-bit bus reach each register one byte at a time.

All inputs are sampled on the block clock. An access begins when chip select is low and either strobe is low. It completes when the strobe is released. Writes act at the release, on the rising edge of the write strobe. The index moves on only when the access just released included the upper byte lane. A write to the lower lane alone is held in a staging byte. It is merged into the register when the upper lane is written. Acknowledge stays low for a configurable number of wait cycles at the start of every access.

Top module: `ixreg_port`

## Requirements
- R1: After reset, every register reads zero, the index is zero, the staged byte is zero, and `ack` and `rd_oe` are low.
- R2: `ack` is low when no access is in progress and for the first `WAIT_CYC` clock cycles of an access. It is high from then until the strobe is released, and it is low again in the cycle after the release.
- R3: While `cs_n` is high, the strobes have no effect. `ack` and `rd_oe` stay low, no register changes and the index does not move.
- R4: A write whose lane enables are `be`=2'b01 (lower lane only) stores `wdata[7:0]` in the staging byte. It leaves the register bank and the index unchanged.
- R5: A write with `be`=2'b10 writes `{wdata[15:8], staged byte}` into the selected register when the strobe is released. The index then advances by one.
- R6: A write with `be`=2'b11 writes all of `wdata[15:0]` into the selected register and advances the index.
- R7: While `cs_n` and `rd_n` are both low, `rd_oe` is high and `rd_data` shows the selected register. A read with `be[1]` low leaves the index where it was. A read with `be[1]` high advances the index when the strobe is released.
- R8: When the index advances from register `NREG-1`, it wraps to register 0.
- R9: A write with `ld` high sets the index to `wdata[IDXW-1:0]` when the strobe is released. It does not change any register.
- R10: A register write does not take effect while the write strobe is still held low. It appears only after the strobe has been released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low. Acts at its release |
| rd_n | input | 1 | Read strobe, active low |
| be | input | 2 | Byte-lane enables: bit 0 = bits 7:0, bit 1 = bits 15:8 |
| ld | input | 1 | When high during a write, the write loads the index |
| wdata | input | 16 | Host write data |
| rd_data | output | 16 | Selected register while a read is active, zero otherwise |
| rd_oe | output | 1 | Read-data drive enable for the host bus |
| ack | output | 1 | Access acknowledge, high once the wait cycles have passed |
| regs_flat | output | NREG*16 | Register bank contents, register k at bits [16k+15:16k] |

## Verification
The bench builds the port with `NREG`=4 and `WAIT_CYC`=2. With only four registers, a few consecutive accesses are enough to reach the wrap from the last register back to the first, for both writes and reads. With two wait cycles, the bench can see a cycle in which the access is active but `ack` is still low, separate from the cycle in which `ack` rises. The vectors go through staged lower-byte writes, upper-only writes, full-width writes, reads of the lower lane only, and index loads. Together these show that the index moves only when the upper lane is released.

// File: rtl/ixreg_pkg.sv
package ixreg_pkg;
    localparam int LANE_W = 8;
    localparam int REG_W  = 2 * LANE_W;
    localparam int LANES  = REG_W / LANE_W;

    // Snapshot of the host strobes and data taken on every cycle of an access
    typedef struct packed {
        logic              act;
        logic              is_wr;
        logic              ld;
        logic [LANES-1:0]  be;
        logic [REG_W-1:0]  data;
    } cap_t;
endpackage

// File: rtl/ixreg_access.sv
module ixreg_access
    import ixreg_pkg::*;
#(
    parameter int WAIT_CYC = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             wr_n,
    input  logic             rd_n,
    input  logic [LANES-1:0] be,
    input  logic             ld,
    input  logic [REG_W-1:0] wdata,
    output cap_t             cap,
    output logic             rel_wr,
    output logic             rel_rd,
    output logic             ack
);
    localparam int CNT_W = $clog2(WAIT_CYC + 2);
    localparam logic [CNT_W-1:0] WAIT_LIM = CNT_W'(WAIT_CYC);

    typedef struct packed {
        cap_t             cap;
        logic [CNT_W-1:0] cnt;
    } acc_st_t;

    acc_st_t st_d, st_q;
    logic    act_now;

    always_comb begin
        act_now = !cs_n && (!wr_n || !rd_n);
        st_d    = st_q;
        if (act_now) begin
            st_d.cap.act   = 1'b1;
            st_d.cap.is_wr = !wr_n;
            st_d.cap.ld    = ld;
            st_d.cap.be    = be;
            st_d.cap.data  = wdata;
            if (st_q.cnt < WAIT_LIM) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end else begin
            st_d.cap.act = 1'b0;
            st_d.cnt     = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // The release is the cycle in which a strobe seen last cycle is gone
    assign rel_wr = st_q.cap.act && !act_now && st_q.cap.is_wr;
    assign rel_rd = st_q.cap.act && !act_now && !st_q.cap.is_wr;
    assign ack    = act_now && (st_q.cnt >= WAIT_LIM);
    assign cap    = st_q.cap;
endmodule

// File: rtl/ixreg_bank.sv
module ixreg_bank
    import ixreg_pkg::*;
#(
    parameter int NREG = 16,
    parameter int IDXW = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [IDXW-1:0]       widx,
    input  logic [REG_W-1:0]      wval,
    input  logic [IDXW-1:0]       ridx,
    output logic [REG_W-1:0]      rval,
    output logic [NREG*REG_W-1:0] regs_flat
);
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [REG_W-1:0] r_d, r_q;

        always_comb begin
            r_d = r_q;
            if (we && (widx == IDXW'(g))) begin
                r_d = wval;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                r_q <= '0;
            end else begin
                r_q <= r_d;
            end
        end

        assign regs_flat[g*REG_W +: REG_W] = r_q;
    end

    always_comb begin
        rval = regs_flat[int'(ridx)*REG_W +: REG_W];
    end
endmodule

// File: rtl/ixreg_port.sv
module ixreg_port
    import ixreg_pkg::*;
#(
    parameter int NREG     = 16,
    parameter int WAIT_CYC = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  wr_n,
    input  logic                  rd_n,
    input  logic [1:0]            be,
    input  logic                  ld,
    input  logic [15:0]           wdata,
    output logic [15:0]           rd_data,
    output logic                  rd_oe,
    output logic                  ack,
    output logic [NREG*16-1:0]    regs_flat
);
    localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;
    localparam logic [IDXW-1:0] LAST_IDX = IDXW'(NREG - 1);

    typedef struct packed {
        logic [IDXW-1:0]   idx;
        logic [LANE_W-1:0] stage;
    } port_st_t;

    port_st_t         st_d, st_q;
    cap_t             cap;
    logic             rel_wr, rel_rd;
    logic             bank_we;
    logic [REG_W-1:0] bank_wv;
    logic [REG_W-1:0] bank_rv;
    logic [IDXW-1:0]  idx_step;
    logic [IDXW-1:0]  idx_load;

    ixreg_access #(.WAIT_CYC(WAIT_CYC)) u_access (
        .clk    (clk),
        .rst_n  (rst_n),
        .cs_n   (cs_n),
        .wr_n   (wr_n),
        .rd_n   (rd_n),
        .be     (be),
        .ld     (ld),
        .wdata  (wdata),
        .cap    (cap),
        .rel_wr (rel_wr),
        .rel_rd (rel_rd),
        .ack    (ack)
    );

    ixreg_bank #(.NREG(NREG), .IDXW(IDXW)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (bank_we),
        .widx      (st_q.idx),
        .wval      (bank_wv),
        .ridx      (st_q.idx),
        .rval      (bank_rv),
        .regs_flat (regs_flat)
    );

    always_comb begin
        st_d     = st_q;
        bank_we  = 1'b0;
        idx_step = (st_q.idx == LAST_IDX) ? '0 : st_q.idx + 1'b1;
        // An out-of-range load (possible only when NREG is not a power of two) selects register 0
        idx_load = (int'(cap.data[IDXW-1:0]) >= NREG) ? '0 : cap.data[IDXW-1:0];
        bank_wv  = {cap.data[REG_W-1:LANE_W],
                    cap.be[0] ? cap.data[LANE_W-1:0] : st_q.stage};

        if (rel_wr && cap.ld) begin
            st_d.idx = idx_load;
        end else if (rel_wr) begin
            if (cap.be[0]) begin
                st_d.stage = cap.data[LANE_W-1:0];
            end
            if (cap.be[1]) begin
                bank_we  = 1'b1;
                st_d.idx = idx_step;
            end
        end else if (rel_rd && cap.be[1]) begin
            st_d.idx = idx_step;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_oe   = !cs_n && !rd_n;
    assign rd_data = rd_oe ? bank_rv : '0;
endmodule

// File: rtl/ixreg_port_chk.sv
module ixreg_port_chk #(
    parameter int NREG     = 16,
    parameter int WAIT_CYC = 1,
    parameter int IDXW     = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cs_n,
    input logic                wr_n,
    input logic                rd_n,
    input logic                ack,
    input logic                rd_oe,
    input logic [NREG*16-1:0]  regs_flat,
    input logic [IDXW-1:0]     idx
);
    logic busy;
    assign busy = !cs_n && (!wr_n || !rd_n);

    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !ack); // R2

    AST_ACK_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (WAIT_CYC > 0) && $rose(busy) |-> !ack); // R2

    AST_CS_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !rd_oe); // R3

    AST_CS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n && $past(cs_n) |=> $stable(regs_flat)); // R3

    AST_HELD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n) |=> $stable(regs_flat)); // R10

    AST_IDX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx) < NREG); // R8
endmodule

bind ixreg_port ixreg_port_chk #(
    .NREG     (NREG),
    .WAIT_CYC (WAIT_CYC),
    .IDXW     (IDXW)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .ack       (ack),
    .rd_oe     (rd_oe),
    .regs_flat (regs_flat),
    .idx       (st_q.idx)
);

// File: tb/ixreg_port_test.sv
module ixreg_port_test;
    localparam int NREG     = 4;
    localparam int WAIT_CYC = 2;
    localparam int NVEC     = 13;
    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_LD = 2'd2;

    // {op, be, data, slot, expected}
    localparam logic [39:0] VEC [NVEC] = '{
        {OP_LD, 2'b00, 16'h0001, 4'd0, 16'h0000},
        {OP_WR, 2'b01, 16'h0034, 4'd1, 16'h0000},
        {OP_WR, 2'b10, 16'h1200, 4'd1, 16'h1234},
        {OP_WR, 2'b11, 16'hBEEF, 4'd2, 16'hBEEF},
        {OP_WR, 2'b11, 16'hCAFE, 4'd3, 16'hCAFE},
        {OP_WR, 2'b11, 16'h0A0B, 4'd0, 16'h0A0B},
        {OP_RD, 2'b01, 16'h0000, 4'd0, 16'h1234},
        {OP_RD, 2'b10, 16'h0000, 4'd0, 16'h1234},
        {OP_RD, 2'b11, 16'h0000, 4'd0, 16'hBEEF},
        {OP_RD, 2'b11, 16'h0000, 4'd0, 16'hCAFE},
        {OP_RD, 2'b11, 16'h0000, 4'd0, 16'h0A0B},
        {OP_LD, 2'b00, 16'h0003, 4'd3, 16'hCAFE},
        {OP_RD, 2'b11, 16'h0000, 4'd0, 16'hCAFE}
    };
    string vtag [NVEC] = '{"R9", "R4", "R5", "R6", "R8", "R8", "R7",
                           "R7", "R7", "R8", "R8", "R9", "R9"};

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, ld = 1'b0;
    logic [1:0]           be = 2'b00;
    logic [15:0]          wdata = '0;
    logic [15:0]          rd_data;
    logic                 rd_oe, ack;
    logic [NREG*16-1:0]   regs_flat;
    int                   checks = 0;
    int                   errors = 0;

    always #4 clk = ~clk;

    ixreg_port #(.NREG(NREG), .WAIT_CYC(WAIT_CYC)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .wr_n      (wr_n),
        .rd_n      (rd_n),
        .be        (be),
        .ld        (ld),
        .wdata     (wdata),
        .rd_data   (rd_data),
        .rd_oe     (rd_oe),
        .ack       (ack),
        .regs_flat (regs_flat)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] slot(input int k);
        return regs_flat[k*16 +: 16];
    endfunction

    task automatic access(input logic [1:0] op, input logic [1:0] b,
                          input logic [15:0] d, output logic [15:0] rv);
        @(negedge clk);
        cs_n  = 1'b0;
        be    = b;
        wdata = d;
        ld    = (op == OP_LD);
        if (op == OP_RD) rd_n = 1'b0;
        else             wr_n = 1'b0;
        #1;
        chk("R2 ack low at access start", {15'd0, ack}, 16'd0);
        rv = rd_data;
        if (op == OP_RD) chk("R7 rd_oe during read", {15'd0, rd_oe}, 16'd1);
        repeat (WAIT_CYC) @(negedge clk);
        chk("R2 ack high after wait", {15'd0, ack}, 16'd1);
        cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; ld = 1'b0; be = 2'b00;
        @(negedge clk);
        chk("R2 ack low after release", {15'd0, ack}, 16'd0);
    endtask

    initial begin
        #(8 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        logic [39:0] v;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 bank zero", {15'd0, |regs_flat}, 16'd0);
        chk("R1 ack low", {15'd0, ack}, 16'd0);
        chk("R1 rd_oe low", {15'd0, rd_oe}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            access(v[39:38], v[37:36], v[35:20], rv);
            if (v[39:38] == OP_RD) chk({vtag[i], " read data"}, rv, v[15:0]);
            else                   chk({vtag[i], " register value"}, slot(int'(v[19:16])), v[15:0]);
        end
        // index is now 0

        // R3: strobes with chip select high
        @(negedge clk);
        wr_n = 1'b0; rd_n = 1'b0; be = 2'b11; wdata = 16'hFFFF;
        repeat (3) begin
            @(negedge clk);
            chk("R3 ack stays low", {15'd0, ack}, 16'd0);
            chk("R3 rd_oe stays low", {15'd0, rd_oe}, 16'd0);
        end
        wr_n = 1'b1; rd_n = 1'b1; be = 2'b00;
        @(negedge clk);
        chk("R3 reg0 unchanged", slot(0), 16'h0A0B);
        access(OP_RD, 2'b11, 16'h0000, rv);
        chk("R3 index unchanged", rv, 16'h0A0B);
        // index is now 1

        // R10: write held for several cycles
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; be = 2'b11; wdata = 16'h5555;
        repeat (3) @(negedge clk);
        chk("R10 no write while held", slot(1), 16'h1234);
        cs_n = 1'b1; wr_n = 1'b1; be = 2'b00;
        @(negedge clk);
        chk("R10 write after release", slot(1), 16'h5555);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule